// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the interrupt state of a bus controller acting as an I2C master. The bit engine, the FIFOs and the bus fabric report events as single-cycle pulses on one 16-bit event input. Each event sets a sticky status bit. A bus-busy level input is shown as a live status bit. A 16-bit enable register selects which status bits drive the single interrupt output.

Software reaches the block through a small register port. The port has a byte offset, a write enable, a read strobe, 16-bit write data and registered 16-bit read data. Status can be read and cleared one bit at a time by writing ones. A second, legacy view returns one small code for the pending event of highest priority. Reading that view clears the event it reports, so repeated reads walk through the pending events.

Top module: `irq_status_unit`

## Requirements
- R1: An event pulse on event bit 0 (lost arbitration), 1 (no acknowledge), 2 (access ready), 3 (receive ready), 4 (transmit ready), 8 (address zero), 9 (addressed as target), 10 (transmit underflow), 11 (receive overrun), 13 (receive drain) or 14 (transmit drain) sets the status bit at the same position. The bit reads as 1 from the cycle after the pulse.
- R2: A write to the status register at offset 0x08 clears every sticky status bit whose write-data bit is 1. It leaves the bits written with 0 unchanged.
- R3: The interrupt output is high exactly when some status bit and the enable bit at the same position are both 1. The enable register sits at offset 0x04. It stores write-data bits 0-4, 8-14 and reads them back.
- R4: A read of the vector register at offset 0x0C returns 1, 2, 3, 4 or 5 when status bit 0, 1, 2, 3 or 4 is the lowest of those five bits that is set. It returns 0 when none of them is set. Enable bits play no part in this.
- R5: A vector read clears the status bit it reports. A following read reports the next pending event, in rising code order.
- R6: Status bit 12 follows the bus-busy input. Writing 1 to it has no effect.
- R7: When an event pulse and a clear hit the same status bit in one cycle, the bit ends up set. The clear may come from a status write or from a vector read.
- R8: Status bits 5, 6, 7 and 15 and enable bits 5, 6, 7 and 15 always read 0. Events and writes on those positions are ignored.
- R9: A synchronous active-low reset clears all status bits, all enable bits and the read data, and drops the interrupt output.
- R10: Read data is registered. It shows the addressed register one cycle after the read strobe and holds its value while no read is made. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_set_i | input | 16 | Single-cycle event pulses, one per status bit position |
| bus_busy_i | input | 1 | Bus-busy level, shown live at status bit 12 |
| reg_addr_i | input | 8 | Byte offset of the register access |
| reg_we_i | input | 1 | Write enable |
| reg_re_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, the enable, status and vector registers at 0x04, 0x08 and 0x0C, and five events in the vector. With these defaults every vector code from 0 to 5 can occur, and the walk through several pending events can be seen read by read. The unused bit positions between the vector events and the FIFO events are also within reach. The table of vectors covers enable and event mixes, including the live busy bit and the unused positions. Directed cases then cover the collisions between a set and a clear, partial clears and a reset in the middle of the test.

// File: rtl/irq_status_pkg.sv
// Shared constants for the interrupt status unit.
// Assumes a 16-bit register width; bit positions are fixed because the
// vector encoder and software decode them.
package irq_status_pkg;

    localparam int REG_W = 16;

    // Status / enable bit positions
    localparam int EV_ARB_LOST   = 0;
    localparam int EV_NO_ACK     = 1;
    localparam int EV_ACC_RDY    = 2;
    localparam int EV_RX_RDY     = 3;
    localparam int EV_TX_RDY     = 4;
    localparam int EV_ADDR_ZERO  = 8;
    localparam int EV_AS_TARGET  = 9;
    localparam int EV_TX_UNDER   = 10;
    localparam int EV_RX_OVER    = 11;
    localparam int EV_BUS_BUSY   = 12;
    localparam int EV_RX_DRAIN   = 13;
    localparam int EV_TX_DRAIN   = 14;

    // Number of low-order events reported by the vector view
    localparam int VEC_EVENTS = 5;

    // Bits latched by event pulses
    localparam logic [REG_W-1:0] STICKY_MASK =
        (REG_W'(1) << EV_ARB_LOST)  | (REG_W'(1) << EV_NO_ACK)    |
        (REG_W'(1) << EV_ACC_RDY)   | (REG_W'(1) << EV_RX_RDY)    |
        (REG_W'(1) << EV_TX_RDY)    | (REG_W'(1) << EV_ADDR_ZERO) |
        (REG_W'(1) << EV_AS_TARGET) | (REG_W'(1) << EV_TX_UNDER)  |
        (REG_W'(1) << EV_RX_OVER)   | (REG_W'(1) << EV_RX_DRAIN)  |
        (REG_W'(1) << EV_TX_DRAIN);

    // Bit driven live from the bus-busy level
    localparam logic [REG_W-1:0] LIVE_MASK = REG_W'(1) << EV_BUS_BUSY;

    // All implemented positions
    localparam logic [REG_W-1:0] IMPL_MASK = STICKY_MASK | LIVE_MASK;

    // Register selected by the current access
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_VECTOR = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_addr_decode.sv
// Decodes the byte offset of a register access into a register select and
// the write / read-side-effect strobes. Assumes at most one access per cycle.
module irq_addr_decode
    import irq_status_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] OFS_ENABLE = ADDR_W'(8'h04),
    parameter logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(8'h08),
    parameter logic [ADDR_W-1:0] OFS_VECTOR = ADDR_W'(8'h0C)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic              re_i,
    output reg_sel_e          sel_o,
    output logic              wr_enable_o,
    output logic              wr_status_o,
    output logic              rd_vector_o
);

    // Map offset onto register select
    always_comb begin
        if (addr_i == OFS_ENABLE)      sel_o = SEL_ENABLE;
        else if (addr_i == OFS_STATUS) sel_o = SEL_STATUS;
        else if (addr_i == OFS_VECTOR) sel_o = SEL_VECTOR;
        else                           sel_o = SEL_NONE;
    end

    // Qualify strobes with the selected register
    always_comb begin
        wr_enable_o = we_i && (sel_o == SEL_ENABLE);
        wr_status_o = we_i && (sel_o == SEL_STATUS);
        rd_vector_o = re_i && (sel_o == SEL_VECTOR);
    end

endmodule

// File: rtl/irq_vector_enc.sv
// Lowest-index-first priority encoder for the vector view.
// Returns code i+1 for the lowest pending bit i, or 0 when none is pending,
// plus a one-hot mask of the reported bit. Purely combinational.
module irq_vector_enc #(
    parameter int NUM_EV = 5,
    localparam int CODE_W = $clog2(NUM_EV + 1)
) (
    input  logic [NUM_EV-1:0] pending_i,
    output logic [CODE_W-1:0] code_o,
    output logic [NUM_EV-1:0] hot_o
);

    // Scan from highest to lowest so the lowest pending bit wins
    always_comb begin
        code_o = '0;
        hot_o  = '0;
        for (int i = NUM_EV - 1; i >= 0; i--) begin
            if (pending_i[i]) begin
                code_o = CODE_W'(i + 1);
                hot_o  = NUM_EV'(1) << i;
            end
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
// Holds the sticky status bits and the enable register.
// Sticky bits are set by event pulses and cleared by write-one or by a
// vector read; a set in the same cycle wins. The busy bit is live.
// Assumes event pulses last one cycle; unimplemented positions stay 0.
module irq_status_bank
    import irq_status_pkg::*;
#(
    parameter int NUM_EV = VEC_EVENTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] w1c_i,
    input  logic [NUM_EV-1:0] vec_clr_i,
    input  logic             en_we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             busy_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] enable_o
);

    logic [REG_W-1:0] sticky_q;
    logic [REG_W-1:0] enable_q;
    logic [REG_W-1:0] clr_all;
    logic [REG_W-1:0] set_masked;

    // Combine both clear sources and mask the set pulses
    always_comb begin
        clr_all    = w1c_i | REG_W'(vec_clr_i);
        set_masked = set_i & STICKY_MASK;
    end

    // Sticky status update: clear first, then set so the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= ((sticky_q & ~clr_all) | set_masked) & STICKY_MASK;
    end

    // Enable register write
    always_ff @(posedge clk) begin
        if (!rst_n)       enable_q <= '0;
        else if (en_we_i) enable_q <= wdata_i & IMPL_MASK;
    end

    // Status view: sticky bits plus live busy
    always_comb begin
        status_o = sticky_q | (busy_i ? LIVE_MASK : '0);
        enable_o = enable_q;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & STICKY_MASK) != '0) |=>
        ((sticky_q & $past(set_i & STICKY_MASK)) == $past(set_i & STICKY_MASK))); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((w1c_i != '0) && (set_i == '0) && (vec_clr_i == '0)) |=>
        (sticky_q == ($past(sticky_q) & ~$past(w1c_i)))); // R2

    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[EV_BUS_BUSY] == busy_i); // R6

endmodule

// File: rtl/irq_status_unit.sv
// Top of the interrupt status and vector unit.
// Connects the decoder, status bank and vector encoder, registers read data
// and drives the interrupt line. Assumes one register access per cycle.
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] OFS_ENABLE = ADDR_W'(8'h04),
    parameter logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(8'h08),
    parameter logic [ADDR_W-1:0] OFS_VECTOR = ADDR_W'(8'h0C),
    parameter int                NUM_EV     = VEC_EVENTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  ev_set_i,
    input  logic              bus_busy_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic              reg_re_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);

    localparam int CODE_W = $clog2(NUM_EV + 1);

    reg_sel_e          sel;
    logic              wr_enable;
    logic              wr_status;
    logic              rd_vector;
    logic [REG_W-1:0]  status_view;
    logic [REG_W-1:0]  enable_view;
    logic [REG_W-1:0]  w1c;
    logic [CODE_W-1:0] vec_code;
    logic [NUM_EV-1:0] vec_hot;
    logic [NUM_EV-1:0] vec_clr;
    logic [REG_W-1:0]  rdata_d;
    logic [REG_W-1:0]  rdata_q;

    irq_addr_decode #(
        .ADDR_W     (ADDR_W),
        .OFS_ENABLE (OFS_ENABLE),
        .OFS_STATUS (OFS_STATUS),
        .OFS_VECTOR (OFS_VECTOR)
    ) u_dec (
        .addr_i      (reg_addr_i),
        .we_i        (reg_we_i),
        .re_i        (reg_re_i),
        .sel_o       (sel),
        .wr_enable_o (wr_enable),
        .wr_status_o (wr_status),
        .rd_vector_o (rd_vector)
    );

    irq_vector_enc #(
        .NUM_EV (NUM_EV)
    ) u_vec (
        .pending_i (status_view[NUM_EV-1:0]),
        .code_o    (vec_code),
        .hot_o     (vec_hot)
    );

    // Clear sources presented to the bank
    always_comb begin
        w1c     = wr_status ? reg_wdata_i : '0;
        vec_clr = rd_vector ? vec_hot : '0;
    end

    irq_status_bank #(
        .NUM_EV (NUM_EV)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (ev_set_i),
        .w1c_i     (w1c),
        .vec_clr_i (vec_clr),
        .en_we_i   (wr_enable),
        .wdata_i   (reg_wdata_i),
        .busy_i    (bus_busy_i),
        .status_o  (status_view),
        .enable_o  (enable_view)
    );

    // Read mux for the selected register
    always_comb begin
        unique case (sel)
            SEL_ENABLE: rdata_d = enable_view;
            SEL_STATUS: rdata_d = status_view;
            SEL_VECTOR: rdata_d = REG_W'(vec_code);
            default:    rdata_d = '0;
        endcase
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (reg_re_i) rdata_q <= rdata_d;
    end

    // Interrupt request from enabled pending status
    always_comb begin
        irq_o       = |(status_view & enable_view);
        reg_rdata_o = rdata_q;
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (enable_view != '0)); // R3

    AST_VEC_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vector && (vec_hot != '0) && ((ev_set_i[NUM_EV-1:0] & vec_hot) == '0)) |=>
        ((status_view[NUM_EV-1:0] & $past(vec_hot)) == '0)); // R5

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vector |=> (reg_rdata_o <= REG_W'(NUM_EV))); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re_i |=> $stable(reg_rdata_o)); // R10

    AST_BUSY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re_i && (sel == SEL_STATUS)) |=>
        (reg_rdata_o[EV_BUS_BUSY] == $past(bus_busy_i))); // R6

endmodule

// File: tb/irq_status_unit_tb_top.sv
// Self-checking bench: a table of event/enable vectors walked by one loop,
// then directed tests for reset, vector order and set/clear collisions.
module irq_status_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [7:0] A_EN  = 8'h04;
    localparam logic [7:0] A_ST  = 8'h08;
    localparam logic [7:0] A_VEC = 8'h0C;

    // {events[15:0], busy, enable[15:0], exp_status[15:0], exp_irq}
    localparam int NTBL = 6;
    localparam logic [49:0] TBL [NTBL] = '{
        {16'h0001, 1'b0, 16'h0001, 16'h0001, 1'b1},
        {16'h0018, 1'b0, 16'h0001, 16'h0018, 1'b0},
        {16'hFFFF, 1'b0, 16'h0000, 16'h6F1F, 1'b0},
        {16'h0000, 1'b1, 16'h1000, 16'h1000, 1'b1},
        {16'h0C00, 1'b1, 16'h0800, 16'h1C00, 1'b1},
        {16'h80E0, 1'b0, 16'hFFFF, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ev_set = '0;
    logic        busy = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    irq_status_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_set_i    (ev_set),
        .bus_busy_i  (busy),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_re_i    (re),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; re = 1'b1;
        @(negedge clk); re = 1'b0; d = rdata;
    endtask

    task automatic pulse(input logic [15:0] e);
        @(negedge clk); ev_set = e;
        @(negedge clk); ev_set = '0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            report();
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: state after reset
        rd(A_ST, d);  check("R9 status after reset", d, 16'h0000);
        rd(A_EN, d);  check("R9 enable after reset", d, 16'h0000);
        rd(A_VEC, d); check("R9 vector after reset", d, 16'h0000);
        check("R9 irq after reset", {15'd0, irq}, 16'h0000);

        // Table walk: R1, R3, R6, R8
        for (int i = 0; i < NTBL; i++) begin
            wr(A_ST, 16'hFFFF);
            busy = TBL[i][33];
            wr(A_EN, TBL[i][32:17]);
            pulse(TBL[i][49:34]);
            check($sformatf("R3 irq row %0d", i), {15'd0, irq}, {15'd0, TBL[i][0]});
            rd(A_ST, d);
            check($sformatf("R1 R8 status row %0d", i), d, TBL[i][16:1]);
        end
        busy = 1'b0;

        // R8: enable stores only implemented bits; R10: unused offset reads 0
        wr(A_EN, 16'hFFFF);
        rd(A_EN, d);   check("R8 enable readback", d, 16'h7F1F);
        rd(8'h10, d);  check("R10 unknown offset", d, 16'h0000);
        wr(A_EN, 16'h0000);

        // R2: partial write-one-to-clear, write of zero
        wr(A_ST, 16'hFFFF);
        pulse(16'h0018);
        wr(A_ST, 16'h0008);
        rd(A_ST, d); check("R2 partial clear", d, 16'h0010);
        wr(A_ST, 16'h0000);
        rd(A_ST, d); check("R2 write zero keeps", d, 16'h0010);

        // R10: read data holds without read strobe
        pulse(16'h0001);
        @(negedge clk);
        check("R10 rdata held", rdata, 16'h0010);

        // R4 R5: vector order and read-to-clear
        wr(A_ST, 16'hFFFF);
        pulse(16'h0016);
        rd(A_VEC, d); check("R4 vector first", d, 16'h0002);
        rd(A_VEC, d); check("R5 vector second", d, 16'h0003);
        rd(A_VEC, d); check("R5 vector third", d, 16'h0005);
        rd(A_VEC, d); check("R4 vector none", d, 16'h0000);
        rd(A_ST, d);  check("R5 status drained", d, 16'h0000);
        pulse(16'h0009);
        rd(A_VEC, d); check("R4 vector code one", d, 16'h0001);
        rd(A_VEC, d); check("R4 vector code four", d, 16'h0004);
        pulse(16'h0800);
        rd(A_VEC, d); check("R4 vector ignores high bits", d, 16'h0000);
        rd(A_ST, d);  check("R5 high bits untouched", d, 16'h0800);

        // R7: set wins over write clear
        wr(A_ST, 16'hFFFF);
        @(negedge clk); addr = A_ST; wdata = 16'h0001; we = 1'b1; ev_set = 16'h0001;
        @(negedge clk); we = 1'b0; ev_set = '0;
        rd(A_ST, d); check("R7 set beats write clear", d, 16'h0001);

        // R7: set wins over vector-read clear
        wr(A_ST, 16'hFFFF);
        pulse(16'h0002);
        @(negedge clk); addr = A_VEC; re = 1'b1; ev_set = 16'h0002;
        @(negedge clk); re = 1'b0; ev_set = '0; d = rdata;
        check("R7 vector code on collision", d, 16'h0002);
        rd(A_ST, d); check("R7 set beats vector clear", d, 16'h0002);

        // R6: busy bit is not cleared by write-one
        busy = 1'b1;
        wr(A_ST, 16'h1000);
        rd(A_ST, d); check("R6 busy survives clear", d, 16'h1002);
        busy = 1'b0;
        rd(A_ST, d); check("R6 busy follows input", d, 16'h0002);

        // R9: reset in the middle of activity
        wr(A_EN, 16'h0002);
        check("R3 irq before reset", {15'd0, irq}, 16'h0001);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R9 irq after mid reset", {15'd0, irq}, 16'h0000);
        check("R9 rdata after mid reset", rdata, 16'h0000);
        rd(A_ST, d); check("R9 status after mid reset", d, 16'h0000);
        rd(A_EN, d); check("R9 enable after mid reset", d, 16'h0000);

        report();
    end

endmodule